// File: doc/BRIEF.md
# Two-dimensional parity tag codec

This block guards a 27-bit virtual page number held in a translation buffer tag array. The data word is viewed as a grid of 3 rows by 9 columns. The encoder side produces 13 check bits for the grid: a parity bit for each row, a parity bit for each column, and a total bit over the column bits. The word and its check bits are stored together as a 40-bit codeword.

On a lookup the stored codeword goes to the decoder side. It recomputes row and column parity and compares them with the stored bits to form two syndromes. It then sorts the result into exactly one of four outcomes: clean, corrected, check bits only, or uncorrectable. The row syndrome and the column syndrome act as coordinates, so a single data flip, or an odd number of flips confined to one row or one column, is located and inverted. A flip that lands only in the check bits is told apart from a data error by comparing the stored total bit with the parity of the stored row bits. The data then passes through untouched, and a flag asks for the check bits to be regenerated.

Any other non-zero pattern is uncorrectable. In that case the data output is the stored data unchanged and must not be used. An optional register stage, selected by a parameter and enabled by default, holds the decoder outputs.

Top module: `tdp_tag_codec`

## Requirements
- R1: `enc_check` bit r (r = 0..2) is the XOR of `enc_data[9r+8:9r]`. Bit 3+c (c = 0..8) is the XOR of `enc_data` bits c, c+9 and c+18. Bit 12 is the XOR of `enc_check[11:3]`.
- R2: The codeword is `{enc_check, enc_data}`, with data in bits 26:0, row bits in 29:27, column bits in 38:30 and the total bit in 39. An intact codeword gives `dec_clean`=1, both syndromes zero, and `dec_data` equal to the stored data.
- R3: A single flip of data bit k gives `dec_fixed`=1 and restores the original data. `dec_row_syn` is one-hot at bit k/9 and `dec_col_syn` is one-hot at bit k%9.
- R4: An odd number of data flips confined to one row, or all three bits of one column, gives `dec_fixed`=1 with the original data restored.
- R5: A single flip of any check bit (row, column or total) gives `dec_chk_only`=1 with the data unchanged. The row syndrome shows a flipped row bit, the column syndrome shows a flipped column bit, and both syndromes are zero when the total bit flipped.
- R6: Any two flipped bits anywhere in the 40-bit codeword give `dec_uncorr`=1 and never `dec_fixed`, and `dec_data` equals the stored data field unchanged.
- R7: An even number (2..8) of contiguous data flips inside one row gives `dec_uncorr`=1.
- R8: Exactly one of `dec_clean`, `dec_fixed`, `dec_chk_only` and `dec_uncorr` is set for each decoded word.
- R9: With the output stage enabled, decoder outputs change only at the clock edge after a codeword is presented. Reset (active low) clears all decoder outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| enc_data | input | 27 | Data word to encode |
| enc_check | output | 13 | Check bits {total, column[8:0], row[2:0]} |
| dec_word | input | 40 | Stored codeword to decode |
| dec_data | output | 27 | Corrected or passed-through data |
| dec_clean | output | 1 | No error found |
| dec_fixed | output | 1 | Data bits were located and inverted |
| dec_chk_only | output | 1 | Only check bits are wrong; regenerate them |
| dec_uncorr | output | 1 | Uncorrectable pattern; data invalid |
| dec_row_syn | output | 3 | Row syndrome |
| dec_col_syn | output | 9 | Column syndrome |

## Verification
The hardest cases to reach are the double flips that combine one data bit with one check bit. Some of them set exactly one row and one column syndrome bit, which looks like a single data error, so a weak classifier would "correct" the wrong bit. The stimulus therefore walks every pair of the 40 codeword positions on fresh random data, which reaches all of these mixed pairs. It also sweeps every contiguous odd and even run inside each row and every full column, which covers the multi-bit correction and the even-burst rejection.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
    localparam int unsigned TDP_ROWS = 3;
    localparam int unsigned TDP_COLS = 9;

    // Outcome of one decode; exactly one field is set after reset.
    typedef struct packed {
        logic clean;
        logic fixed;
        logic chk_only;
        logic uncorr;
    } tdp_flags_t;
endpackage

// File: rtl/tdp_parity_gen.sv
module tdp_parity_gen #(
    parameter int unsigned ROWS = tdp_pkg::TDP_ROWS,
    parameter int unsigned COLS = tdp_pkg::TDP_COLS,
    localparam int unsigned DW  = ROWS * COLS
) (
    input  logic [DW-1:0]   data,
    output logic [ROWS-1:0] row_par,
    output logic [COLS-1:0] col_par
);
    // Row r covers data[r*COLS +: COLS]; folding the rows onto each other
    // with XOR gives column parity, since column c holds bit c of every row.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_par[r] = ^data[r*COLS +: COLS];
    end

    always_comb begin
        col_par = '0;
        for (int r = 0; r < ROWS; r++) begin
            col_par = col_par ^ data[r*COLS +: COLS];
        end
    end
endmodule

// File: rtl/tdp_classify.sv
module tdp_classify
    import tdp_pkg::*;
#(
    parameter int unsigned ROWS = TDP_ROWS,
    parameter int unsigned COLS = TDP_COLS,
    localparam int unsigned DW  = ROWS * COLS
) (
    input  logic [ROWS-1:0] row_syn,
    input  logic [COLS-1:0] col_syn,
    input  logic            tot_mis,   // stored total xor parity of stored row bits
    output tdp_flags_t      flags,
    output logic [DW-1:0]   flip_mask
);
    int unsigned n_row;
    int unsigned n_col;
    logic r_any, c_any, r_one, c_one, r_odd, c_odd;
    logic fix_ok, chk_ok;

    always_comb begin
        n_row = 0;
        n_col = 0;
        for (int r = 0; r < ROWS; r++) n_row = n_row + 32'(row_syn[r]);
        for (int c = 0; c < COLS; c++) n_col = n_col + 32'(col_syn[c]);
        r_any = |row_syn;
        c_any = |col_syn;
        r_one = (n_row == 1);
        c_one = (n_col == 1);
        r_odd = ^row_syn;
        c_odd = ^col_syn;

        // Data-only errors leave the stored row bits and total untouched,
        // so tot_mis must be clear for a coordinate correction.
        fix_ok = !tot_mis && ((r_one && c_odd) || (c_one && r_odd));

        // Lone check-bit flips: total bit, one row bit, or one column bit.
        chk_ok = (!r_any && !c_any &&  tot_mis) ||
                 ( r_one && !c_any &&  tot_mis) ||
                 (!r_any &&  c_one && !tot_mis);

        flags.clean    = !r_any && !c_any && !tot_mis;
        flags.fixed    = fix_ok;
        flags.chk_only = chk_ok;
        flags.uncorr   = !(!r_any && !c_any && !tot_mis) && !fix_ok && !chk_ok;
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_mr
        for (genvar c = 0; c < COLS; c++) begin : g_mc
            assign flip_mask[r*COLS + c] = fix_ok & row_syn[r] & col_syn[c];
        end
    end
endmodule

// File: rtl/tdp_tag_codec.sv
module tdp_tag_codec
    import tdp_pkg::*;
#(
    parameter int unsigned ROWS    = TDP_ROWS,
    parameter int unsigned COLS    = TDP_COLS,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned DW     = ROWS * COLS,
    localparam int unsigned CW     = ROWS + COLS + 1,
    localparam int unsigned WW     = DW + CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   enc_data,
    output logic [CW-1:0]   enc_check,
    input  logic [WW-1:0]   dec_word,
    output logic [DW-1:0]   dec_data,
    output logic            dec_clean,
    output logic            dec_fixed,
    output logic            dec_chk_only,
    output logic            dec_uncorr,
    output logic [ROWS-1:0] dec_row_syn,
    output logic [COLS-1:0] dec_col_syn
);
    typedef struct packed {
        logic [DW-1:0]   data;
        tdp_flags_t      flags;
        logic [ROWS-1:0] rsyn;
        logic [COLS-1:0] csyn;
    } res_t;

    // ---------------- encoder ----------------
    logic [ROWS-1:0] enc_row;
    logic [COLS-1:0] enc_col;

    tdp_parity_gen #(.ROWS(ROWS), .COLS(COLS)) u_enc (
        .data    (enc_data),
        .row_par (enc_row),
        .col_par (enc_col)
    );

    assign enc_check = {^enc_col, enc_col, enc_row};

    // ---------------- decoder ----------------
    logic [DW-1:0]   st_data;
    logic [ROWS-1:0] st_row;
    logic [COLS-1:0] st_col;
    logic            st_tot;
    logic [ROWS-1:0] re_row;
    logic [COLS-1:0] re_col;
    logic [ROWS-1:0] row_syn;
    logic [COLS-1:0] col_syn;
    logic            tot_mis;
    tdp_flags_t      flags;
    logic [DW-1:0]   flip_mask;

    assign st_data = dec_word[DW-1:0];
    assign st_row  = dec_word[DW +: ROWS];
    assign st_col  = dec_word[DW+ROWS +: COLS];
    assign st_tot  = dec_word[WW-1];

    tdp_parity_gen #(.ROWS(ROWS), .COLS(COLS)) u_dec (
        .data    (st_data),
        .row_par (re_row),
        .col_par (re_col)
    );

    assign row_syn = st_row ^ re_row;
    assign col_syn = st_col ^ re_col;
    assign tot_mis = st_tot ^ (^st_row);

    tdp_classify #(.ROWS(ROWS), .COLS(COLS)) u_cls (
        .row_syn   (row_syn),
        .col_syn   (col_syn),
        .tot_mis   (tot_mis),
        .flags     (flags),
        .flip_mask (flip_mask)
    );

    res_t res_d;
    res_t res_q;

    always_comb begin
        res_d.data  = st_data ^ flip_mask;
        res_d.flags = flags;
        res_d.rsyn  = row_syn;
        res_d.csyn  = col_syn;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end
    end else begin : g_comb
        always_comb res_q = res_d;
    end

    assign dec_data     = res_q.data;
    assign dec_clean    = res_q.flags.clean;
    assign dec_fixed    = res_q.flags.fixed;
    assign dec_chk_only = res_q.flags.chk_only;
    assign dec_uncorr   = res_q.flags.uncorr;
    assign dec_row_syn  = res_q.rsyn;
    assign dec_col_syn  = res_q.csyn;
endmodule

// File: rtl/tdp_tag_codec_chk.sv
module tdp_tag_codec_chk #(
    parameter int unsigned ROWS    = tdp_pkg::TDP_ROWS,
    parameter int unsigned COLS    = tdp_pkg::TDP_COLS,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned DW     = ROWS * COLS,
    localparam int unsigned WW     = DW + ROWS + COLS + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [WW-1:0]   dec_word,
    input logic [DW-1:0]   dec_data,
    input logic            dec_clean,
    input logic            dec_fixed,
    input logic            dec_chk_only,
    input logic            dec_uncorr,
    input logic [ROWS-1:0] dec_row_syn,
    input logic [COLS-1:0] dec_col_syn
);
    logic [DW-1:0] seen_q;
    logic [DW-1:0] ref_data;

    always_ff @(posedge clk) seen_q <= dec_word[DW-1:0];
    assign ref_data = REG_OUT ? seen_q : dec_word[DW-1:0];

    // R8: never more than one outcome flag
    a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec_clean, dec_fixed, dec_chk_only, dec_uncorr}));

    // R2: clean result has quiet syndromes and untouched data
    a_r2_clean_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dec_clean |-> (dec_row_syn == '0 && dec_col_syn == '0 && dec_data == ref_data));

    // R5: check-only result passes data and shows at most one syndrome bit
    a_r5_chk_pass: assert property (@(posedge clk) disable iff (!rst_n)
        dec_chk_only |-> (dec_data == ref_data &&
                          ($countones(dec_row_syn) + $countones(dec_col_syn)) <= 1));

    // R3/R4: a correction inverts exactly the addressed grid points along one line
    a_r3_fix_weight: assert property (@(posedge clk) disable iff (!rst_n)
        dec_fixed |-> ($countones(dec_data ^ ref_data) ==
                       $countones(dec_row_syn) * $countones(dec_col_syn) &&
                       ($countones(dec_row_syn) == 1 || $countones(dec_col_syn) == 1)));

    // R6: uncorrectable leaves data alone and always has a non-zero syndrome
    a_r6_uncorr_pass: assert property (@(posedge clk) disable iff (!rst_n)
        dec_uncorr |-> (dec_data == ref_data && (dec_row_syn != '0 || dec_col_syn != '0)));
endmodule

bind tdp_tag_codec tdp_tag_codec_chk #(
    .ROWS(ROWS), .COLS(COLS), .REG_OUT(REG_OUT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_word     (dec_word),
    .dec_data     (dec_data),
    .dec_clean    (dec_clean),
    .dec_fixed    (dec_fixed),
    .dec_chk_only (dec_chk_only),
    .dec_uncorr   (dec_uncorr),
    .dec_row_syn  (dec_row_syn),
    .dec_col_syn  (dec_col_syn)
);

// File: tb/tdp_tag_codec_test.sv
module tdp_tag_codec_test;
    localparam int DW = 27;
    localparam int WW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] enc_data = '0;
    logic [12:0]   enc_check;
    logic [WW-1:0] dec_word = '0;
    logic [DW-1:0] dec_data;
    logic          dec_clean, dec_fixed, dec_chk_only, dec_uncorr;
    logic [2:0]    dec_row_syn;
    logic [8:0]    dec_col_syn;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tdp_tag_codec uut (
        .clk(clk), .rst_n(rst_n),
        .enc_data(enc_data), .enc_check(enc_check),
        .dec_word(dec_word), .dec_data(dec_data),
        .dec_clean(dec_clean), .dec_fixed(dec_fixed),
        .dec_chk_only(dec_chk_only), .dec_uncorr(dec_uncorr),
        .dec_row_syn(dec_row_syn), .dec_col_syn(dec_col_syn)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Bench-side encoder, written as a grid walk.
    function automatic logic [WW-1:0] mk_word(input logic [DW-1:0] d);
        logic [2:0] a = '0;
        logic [8:0] col = '0;
        logic t = 1'b0;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 9; c++) begin
                a[r]   = a[r]   ^ d[9*r + c];
                col[c] = col[c] ^ d[9*r + c];
            end
        for (int c = 0; c < 9; c++) t = t ^ col[c];
        return {t, col, a, d};
    endfunction

    function automatic logic [DW-1:0] rnd_data();
        return DW'({$urandom, $urandom});
    endfunction

    // Present a codeword and sample one clock later, away from the edge.
    task automatic decode(input logic [WW-1:0] w);
        @(negedge clk);
        dec_word = w;
        @(negedge clk);
    endtask

    task automatic chk_flags(input string req, input logic [3:0] exp);
        chk(req, "flags{clean,fixed,chk,uncorr}",
            {dec_clean, dec_fixed, dec_chk_only, dec_uncorr}, exp);
        chk("R8", "one flag", $countones({dec_clean, dec_fixed, dec_chk_only, dec_uncorr}), 1);
    endtask

    task automatic t_reset();
        #1;
        chk("R9", "reset data", dec_data, 0);
        chk("R9", "reset flags", {dec_clean, dec_fixed, dec_chk_only, dec_uncorr}, 0);
        chk("R9", "reset syn", {dec_row_syn, dec_col_syn}, 0);
    endtask

    task automatic t_encode();
        logic [WW-1:0] w;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            enc_data = (n == 0) ? '0 : (n == 1) ? '1 : rnd_data();
            #1;
            w = mk_word(enc_data);
            chk("R1", "enc_check", enc_check, w[WW-1:DW]);
        end
    endtask

    task automatic t_clean();
        for (int n = 0; n < 20; n++) begin
            logic [DW-1:0] d = rnd_data();
            decode(mk_word(d));
            chk_flags("R2", 4'b1000);
            chk("R2", "data", dec_data, d);
            chk("R2", "syn", {dec_row_syn, dec_col_syn}, 0);
        end
    endtask

    task automatic t_single();
        for (int i = 0; i < WW; i++) begin
            logic [DW-1:0] d = rnd_data();
            decode(mk_word(d) ^ (WW'(1) << i));
            chk(i < DW ? "R3" : "R5", "data", dec_data, d);
            if (i < DW) begin
                chk_flags("R3", 4'b0100);
                chk("R3", "row syn", dec_row_syn, 3'(1) << (i / 9));
                chk("R3", "col syn", dec_col_syn, 9'(1) << (i % 9));
            end else if (i < DW + 3) begin
                chk_flags("R5", 4'b0010);
                chk("R5", "row syn", dec_row_syn, 3'(1) << (i - DW));
                chk("R5", "col syn", dec_col_syn, 0);
            end else if (i < WW - 1) begin
                chk_flags("R5", 4'b0010);
                chk("R5", "row syn", dec_row_syn, 0);
                chk("R5", "col syn", dec_col_syn, 9'(1) << (i - DW - 3));
            end else begin
                chk_flags("R5", 4'b0010);
                chk("R5", "syn total", {dec_row_syn, dec_col_syn}, 0);
            end
        end
    endtask

    task automatic t_double();
        for (int i = 0; i < WW; i++)
            for (int j = i + 1; j < WW; j++) begin
                logic [DW-1:0] d = rnd_data();
                logic [WW-1:0] w = mk_word(d) ^ (WW'(1) << i) ^ (WW'(1) << j);
                decode(w);
                chk_flags("R6", 4'b0001);
                chk("R6", "data pass", dec_data, w[DW-1:0]);
            end
    endtask

    task automatic t_row_runs();
        for (int r = 0; r < 3; r++)
            for (int len = 1; len <= 9; len++)
                for (int s = 0; s + len <= 9; s++) begin
                    logic [DW-1:0] d = rnd_data();
                    logic [DW-1:0] m = '0;
                    logic [WW-1:0] w;
                    for (int k = 0; k < len; k++) m[9*r + s + k] = 1'b1;
                    w = mk_word(d) ^ {13'b0, m};
                    decode(w);
                    if (len % 2 == 1) begin
                        chk_flags("R4", 4'b0100);
                        chk("R4", "row run data", dec_data, d);
                    end else begin
                        chk_flags("R7", 4'b0001);
                        chk("R7", "even run data", dec_data, w[DW-1:0]);
                    end
                end
    endtask

    task automatic t_col_triple();
        for (int c = 0; c < 9; c++) begin
            logic [DW-1:0] d = rnd_data();
            logic [DW-1:0] m = '0;
            m[c] = 1'b1; m[c + 9] = 1'b1; m[c + 18] = 1'b1;
            decode(mk_word(d) ^ {13'b0, m});
            chk_flags("R4", 4'b0100);
            chk("R4", "column data", dec_data, d);
            chk("R4", "column row syn", dec_row_syn, 3'b111);
        end
    endtask

    task automatic t_latency();
        logic [DW-1:0] d = rnd_data();
        decode(mk_word(d));
        @(negedge clk);
        dec_word = mk_word(d) ^ (WW'(1) << 5);
        #1;
        chk("R9", "held before edge", {dec_clean, dec_fixed}, 2'b10);
        @(negedge clk);
        chk("R9", "after edge", {dec_clean, dec_fixed}, 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_encode();
        t_clean();
        t_single();
        t_double();
        t_row_runs();
        t_col_triple();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule